// File: doc/BRIEF.md
# Module Power-State Transition Controller

This block moves a set of peripheral modules between four power states. Each state is a combination of clock gating and reset. Software writes a requested state into each module's control register. Those writes have no effect until software writes the command register. That write starts one transition that covers every module whose request differs from the state it has reached.

During the transition a busy flag stays set. When a module's gating logic acknowledges, and a fixed settling count has run out, that module's status register takes the requested code. The busy flag clears once every module has finished. Software polls the busy flag and then reads each status register to confirm that it matches the request.

The register bus is a plain write strobe, a byte address and a combinational read port. It has no handshake and no back-pressure. The acknowledge inputs and the clock-enable and reset outputs are plain per-module level signals.

Top module: `pstc_top`

## Requirements
- R1: After reset, every control and status register reads 0. The busy flag reads 0. Every module's clock enable is 0 and every module's reset output is 0, meaning the reset is asserted.
- R2: Each module n has two registers. Its control register is at byte address 0x400+4n and its status register is at 0x800+4n. The state code is held in bits [5:0]. A control write is stored and reads back the next cycle, but it changes neither the status registers nor the module outputs until a command is accepted.
- R3: A control write whose code is above 3 is discarded, and the register keeps its previous value.
- R4: The command register is at byte address 0x000. Writing it with bit 0 set while the controller is idle starts a transition. A write with bit 0 clear does nothing.
- R5: The busy flag is bit 0 of address 0x004. It reads 1 from the edge that accepts the command until the edge on which the last changing module completes. With ACK_CYCLES = K, a module completes K+1 edges after the command edge if its acknowledge input is high. If the acknowledge input is low, the module waits for it.
- R6: When a module completes, its status code equals the code it was asked for. Before that, its status keeps the old code.
- R7: From the command edge, the outputs of each changing module follow its requested code. Code 0 gives clock enable 0 and reset output 0. Code 1 gives clock enable 1 and reset output 0. Code 2 gives clock enable 0 and reset output 1. Code 3 gives clock enable 1 and reset output 1. A reset output of 1 means the module is out of reset.
- R8: A command write made while busy is ignored. It changes neither the outputs nor the codes that the status registers finally reach.
- R9: A command issued when no module's request differs from its status starts nothing, and the busy flag stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Byte address for reads and writes |
| reg_wdata | input | 6 | Write data |
| reg_rdata | output | 6 | Combinational read data for reg_addr |
| gate_ack | input | N_MOD | Per-module acknowledge from the gating logic |
| mod_clk_en | output | N_MOD | Per-module clock enable |
| mod_rst_n | output | N_MOD | Per-module reset, 0 holds the module in reset |

## Verification
The command write is captured on one edge. On that edge the busy flag and the module outputs change, so the bench reads them in the low half of that same cycle. Status codes change on the edge that is K+1 edges after the command, and the busy flag drops on that edge. The bench therefore reads busy still at 1 after K edges and reads the final values after edge K+1. A control write also appears on its capture edge, and the bench reads it back right after that edge.

// File: rtl/pstc_pkg.sv
package pstc_pkg;
  localparam int unsigned ST_W = 6;
  typedef logic [ST_W-1:0] pstate_t;

  localparam pstate_t ST_RST_OFF  = 6'd0;
  localparam pstate_t ST_RST_SYNC = 6'd1;
  localparam pstate_t ST_DISABLED = 6'd2;
  localparam pstate_t ST_ENABLED  = 6'd3;

  function automatic logic code_ok(pstate_t c);
    return c <= ST_ENABLED;
  endfunction

  function automatic logic code_clk_on(pstate_t c);
    return (c == ST_RST_SYNC) || (c == ST_ENABLED);
  endfunction

  function automatic logic code_rst_rel(pstate_t c);
    return (c == ST_DISABLED) || (c == ST_ENABLED);
  endfunction
endpackage

// File: rtl/pstc_addr_dec.sv
module pstc_addr_dec #(
  parameter int unsigned N_MOD     = 4,
  parameter int unsigned AW        = 12,
  parameter int unsigned CMD_OFS   = 'h000,
  parameter int unsigned TSTAT_OFS = 'h004,
  parameter int unsigned CTL_BASE  = 'h400,
  parameter int unsigned STAT_BASE = 'h800
) (
  input  logic [AW-1:0]    addr,
  output logic             hit_cmd,
  output logic             hit_tstat,
  output logic [N_MOD-1:0] hit_ctl,
  output logic [N_MOD-1:0] hit_stat
);
  localparam logic [AW-1:0] A_CMD   = AW'(CMD_OFS);
  localparam logic [AW-1:0] A_TSTAT = AW'(TSTAT_OFS);

  assign hit_cmd   = (addr == A_CMD);
  assign hit_tstat = (addr == A_TSTAT);

  for (genvar i = 0; i < N_MOD; i++) begin : g_dec
    localparam logic [AW-1:0] A_CTL  = AW'(CTL_BASE + 4 * i);
    localparam logic [AW-1:0] A_STAT = AW'(STAT_BASE + 4 * i);
    assign hit_ctl[i]  = (addr == A_CTL);
    assign hit_stat[i] = (addr == A_STAT);
  end
endmodule

// File: rtl/pstc_slice.sv
module pstc_slice
  import pstc_pkg::*;
#(
  parameter int unsigned ACK_CYCLES = 4
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    ctl_we,
  input  pstate_t wdata,
  input  logic    go,
  input  logic    ack,
  output pstate_t next_st,
  output pstate_t cur_st,
  output logic    pending,
  output logic    clk_en,
  output logic    rst_rel
);
  localparam int unsigned CW = $clog2(ACK_CYCLES + 2);
  localparam logic [CW-1:0] CNT_LOAD = CW'(ACK_CYCLES);

  pstate_t        drive_q;
  logic [CW-1:0]  cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      next_st <= ST_RST_OFF;
      cur_st  <= ST_RST_OFF;
      drive_q <= ST_RST_OFF;
      pending <= 1'b0;
      cnt_q   <= '0;
    end else begin
      if (ctl_we && code_ok(wdata)) next_st <= wdata;
      if (go && (next_st != cur_st)) begin
        drive_q <= next_st;
        pending <= 1'b1;
        cnt_q   <= CNT_LOAD;
      end else if (pending) begin
        if (cnt_q != '0) begin
          cnt_q <= cnt_q - 1'b1;
        end else if (ack) begin
          cur_st  <= drive_q;
          pending <= 1'b0;
        end
      end
    end
  end

  assign clk_en  = code_clk_on(drive_q);
  assign rst_rel = code_rst_rel(drive_q);

  AST_DONE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pending) |-> (cur_st == drive_q)); // R6
  AST_IDLE_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending && !go) |=> $stable(cur_st)); // R6
  AST_ACK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !ack) |=> pending); // R5
  AST_IDLE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    !pending |-> (clk_en == code_clk_on(cur_st)) && (rst_rel == code_rst_rel(cur_st))); // R7
  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    next_st <= ST_ENABLED); // R3
endmodule

// File: rtl/pstc_top.sv
module pstc_top
  import pstc_pkg::*;
#(
  parameter int unsigned N_MOD      = 4,
  parameter int unsigned ACK_CYCLES = 4,
  parameter int unsigned AW         = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [AW-1:0]    reg_addr,
  input  logic [ST_W-1:0]  reg_wdata,
  output logic [ST_W-1:0]  reg_rdata,
  input  logic [N_MOD-1:0] gate_ack,
  output logic [N_MOD-1:0] mod_clk_en,
  output logic [N_MOD-1:0] mod_rst_n
);
  logic             hit_cmd, hit_tstat;
  logic [N_MOD-1:0] hit_ctl, hit_stat, pend;
  pstate_t          next_arr [N_MOD];
  pstate_t          cur_arr  [N_MOD];
  logic             busy, go_acc;

  pstc_addr_dec #(.N_MOD(N_MOD), .AW(AW)) u_dec (
    .addr(reg_addr), .hit_cmd(hit_cmd), .hit_tstat(hit_tstat),
    .hit_ctl(hit_ctl), .hit_stat(hit_stat)
  );

  assign busy   = |pend;
  assign go_acc = reg_we && hit_cmd && reg_wdata[0] && !busy;

  for (genvar i = 0; i < N_MOD; i++) begin : g_mod
    pstc_slice #(.ACK_CYCLES(ACK_CYCLES)) u_slice (
      .clk(clk), .rst_n(rst_n),
      .ctl_we(reg_we && hit_ctl[i]), .wdata(reg_wdata),
      .go(go_acc), .ack(gate_ack[i]),
      .next_st(next_arr[i]), .cur_st(cur_arr[i]), .pending(pend[i]),
      .clk_en(mod_clk_en[i]), .rst_rel(mod_rst_n[i])
    );
  end

  always_comb begin
    reg_rdata = '0;
    if (hit_tstat) reg_rdata[0] = busy;
    for (int i = 0; i < N_MOD; i++) begin
      if (hit_ctl[i])  reg_rdata = next_arr[i];
      if (hit_stat[i]) reg_rdata = cur_arr[i];
    end
  end

  AST_GO_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_we && hit_cmd) |=> ($stable(mod_clk_en) && $stable(mod_rst_n))); // R8
  AST_BUSY_ON_GO: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && reg_we && hit_cmd && !reg_wdata[0]) |=> !busy); // R4
endmodule

// File: tb/sim_pstc_top.sv
module sim_pstc_top;
  localparam int N = 4;
  localparam int K = 4;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       reg_we = 0;
  logic [11:0] reg_addr = 0;
  logic [5:0] reg_wdata = 0;
  logic [5:0] reg_rdata;
  logic [N-1:0] gate_ack = '1;
  logic [N-1:0] mod_clk_en, mod_rst_n;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pstc_top #(.N_MOD(N), .ACK_CYCLES(K)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .gate_ack(gate_ack),
    .mod_clk_en(mod_clk_en), .mod_rst_n(mod_rst_n)
  );

  // each entry: four requested codes, module 0 in the low 6 bits
  localparam int NV = 6;
  localparam logic [23:0] VEC [NV] = '{
    {6'd3, 6'd2, 6'd1, 6'd3},
    {6'd0, 6'd3, 6'd3, 6'd2},
    {6'd2, 6'd2, 6'd0, 6'd1},
    {6'd1, 6'd0, 6'd2, 6'd0},
    {6'd3, 6'd3, 6'd3, 6'd3},
    {6'd2, 6'd1, 6'd0, 6'd3}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [5:0] d);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [11:0] a, output int v);
    reg_addr = a;
    #1;
    v = int'(reg_rdata);
  endtask

  function automatic int exp_clk(input logic [23:0] v);
    int r = 0;
    for (int m = 0; m < N; m++) begin
      int c = int'(v[m*6 +: 6]);
      if (c == 1 || c == 3) r |= (1 << m);
    end
    return r;
  endfunction

  function automatic int exp_rst(input logic [23:0] v);
    int r = 0;
    for (int m = 0; m < N; m++) begin
      int c = int'(v[m*6 +: 6]);
      if (c == 2 || c == 3) r |= (1 << m);
    end
    return r;
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    int v;
    logic [23:0] cur_v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R1 reset state
    rd(12'h004, v); chk("R1 busy", v, 0);
    for (int m = 0; m < N; m++) begin
      rd(12'h400 + 12'(4*m), v); chk("R1 ctl", v, 0);
      rd(12'h800 + 12'(4*m), v); chk("R1 stat", v, 0);
    end
    chk("R1 clk_en", int'(mod_clk_en), 0);
    chk("R1 rst_n", int'(mod_rst_n), 0);
    cur_v = '0;

    // R9 command with nothing to change
    wr(12'h000, 6'd1);
    rd(12'h004, v); chk("R9 busy stays 0", v, 0);

    // table walk: R2 R4 R5 R6 R7
    for (int t = 0; t < NV; t++) begin
      for (int m = 0; m < N; m++) wr(12'h400 + 12'(4*m), VEC[t][m*6 +: 6]);
      rd(12'h404, v); chk("R2 ctl readback", v, int'(VEC[t][11:6]));
      rd(12'h804, v); chk("R2 stat before go", v, int'(cur_v[11:6]));
      chk("R2 outputs before go", int'(mod_clk_en), exp_clk(cur_v));
      wr(12'h000, 6'd0);
      rd(12'h004, v); chk("R4 bit0 clear no start", v, 0);
      wr(12'h000, 6'd1);
      rd(12'h004, v); chk("R5 busy after go", v, (VEC[t] != cur_v) ? 1 : 0);
      chk("R7 clk_en at go", int'(mod_clk_en), exp_clk(VEC[t]));
      chk("R7 rst_n at go", int'(mod_rst_n), exp_rst(VEC[t]));
      repeat (K) @(negedge clk);
      rd(12'h004, v); chk("R5 busy at K", v, (VEC[t] != cur_v) ? 1 : 0);
      @(negedge clk);
      rd(12'h004, v); chk("R5 busy clear at K+1", v, 0);
      for (int m = 0; m < N; m++) begin
        rd(12'h800 + 12'(4*m), v); chk("R6 stat match", v, int'(VEC[t][m*6 +: 6]));
      end
      cur_v = VEC[t];
    end

    // R3 illegal code discarded
    wr(12'h408, 6'd5);
    rd(12'h408, v); chk("R3 code 5 dropped", v, int'(cur_v[17:12]));
    wr(12'h408, 6'd63);
    rd(12'h408, v); chk("R3 code 63 dropped", v, int'(cur_v[17:12]));

    // R5 ack held low stalls module 1
    wr(12'h404, 6'd3);
    gate_ack[1] = 1'b0;
    wr(12'h000, 6'd1);
    repeat (K + 4) @(negedge clk);
    rd(12'h004, v); chk("R5 busy while ack low", v, 1);
    rd(12'h804, v); chk("R6 stat old while waiting", v, int'(cur_v[11:6]));
    gate_ack[1] = 1'b1;
    @(negedge clk);
    rd(12'h004, v); chk("R5 busy clear after ack", v, 0);
    rd(12'h804, v); chk("R6 stat after ack", v, 3);
    cur_v[11:6] = 6'd3;

    // R8 go while busy ignored
    wr(12'h400, 6'd0);
    wr(12'h000, 6'd1);
    wr(12'h40C, 6'd1);
    wr(12'h000, 6'd1);
    chk("R8 clk_en unchanged", int'(mod_clk_en[3]), cur_v[23:18] == 1 || cur_v[23:18] == 3);
    repeat (K + 2) @(negedge clk);
    rd(12'h004, v); chk("R8 idle", v, 0);
    rd(12'h800, v); chk("R8 stat mod0", v, 0);
    rd(12'h80C, v); chk("R8 stat mod3 untouched", v, int'(cur_v[23:18]));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule